// File: doc/BRIEF.md
# In-Band Flow-Control Calendar Sender

This block feeds the transmit framer of a packet link with in-band flow-control bits. The user side presents a calendar vector of one or more 16-bit pages, one bit per channel or group, where 1 means the far end may keep sending (XON) and 0 asks it to hold (XOFF). If flow control is unused, the calendar should be held at all ones. Whenever the framer builds a control word, either a burst word or an idle word, it pulses a slot strobe. In that same cycle the block returns the calendar page that belongs in that word, plus a flag that marks the first page of a set. It also returns a 64-bit overlay with both already placed at their control-word positions, so the framer can OR it into the word.

Pages leave in order, from the most significant page down to the least significant, one per slot. When the first page of a set goes out, the whole calendar is copied into a holding register. Every later page of that set is taken from this copy, so one set never mixes two calendar values. The slot strobe is a plain control input and is not a valid/ready stream. The framer cannot stall a control word, so the block has no back-pressure path. It answers every slot in the same cycle, and it always accepts a slot. Calendar bits pass through unchanged, and they need no alignment to packet boundaries.

Top module: `fcal_tx`

## Requirements
- R1: After reset, and after any reset that interrupts a set, the first slot sends the most significant page with the reset-calendar flag at 1.
- R2: In consecutive slots, pages are sent from the most significant page (`cal_in[CAL_W-1 -: 16]`) down to the least significant page (`cal_in[15:0]`), one page per slot.
- R3: The reset-calendar flag is 1 on the first slot of each set and 0 on every other slot of the set.
- R4: During a slot, overlay bit 56 equals the flag, overlay bits [55:40] equal the page with the page MSB at bit 55 and the page LSB at bit 40, and every other overlay bit is 0.
- R5: The first page of a set is taken live from `cal_in` in its own slot, and the rest of the calendar is captured in that cycle. Changes to `cal_in` after that slot do not affect the later pages of the set.
- R6: When `slot_req` is 0, the flag, the page and the overlay are all 0, and the page position does not move.
- R7: The slot after the least significant page starts a new set. That slot has the flag at 1 and takes a fresh capture of the calendar.
- R8: With `NUM_PAGES` = 1, every slot carries the flag at 1 and the live 16-bit calendar.
- R9: Calendar bit values, including all ones (XON) and all zeros (XOFF), are passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit user clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_in | input | NUM_PAGES*16 | Calendar vector; 1 = XON, 0 = XOFF |
| slot_req | input | 1 | Framer is building a burst or idle control word in this cycle |
| cw_rst_cal | output | 1 | Reset-calendar flag for this control word |
| cw_fc_page | output | 16 | In-band flow-control page for this control word |
| cw_overlay | output | 64 | Flag at bit 56 and page at bits [55:40], zeros elsewhere |

## Verification
The hardest case to reach is a calendar that changes partway through a set. In that case the later pages must still come from the capture taken at the first page, while the next set must pick up the new value. The stimulus changes `cal_in` in the very slot after a set's first page and keeps changing it during the set's remaining slots. It then sends one more slot to cross the wrap. A reset is also applied in the middle of a set, to show that the sequence restarts at the most significant page. Idle gaps of different lengths between slots show that the position is held between them.

// File: rtl/fcal_pkg.sv
package fcal_pkg;
  localparam int PAGE_W  = 16;
  localparam int CW_W    = 64;
  localparam int RST_BIT = 56;
  localparam int FC_LSB  = 40;
  localparam int FC_MSB  = FC_LSB + PAGE_W - 1;

  function automatic bit pages_legal(input int n);
    return (n == 1) || (n == 2) || (n == 4) || (n == 8) || (n == 16);
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fcal_page_seq.sv
module fcal_page_seq
  import fcal_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int IW = idx_width(NUM_PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_req,
  output logic [IW-1:0] page_idx,
  output logic          set_first
);
  generate
    if (NUM_PAGES == 1) begin : g_single
      assign page_idx  = '0;
      assign set_first = 1'b1;
    end else begin : g_multi
      localparam logic [IW-1:0] LAST = IW'(NUM_PAGES - 1);
      logic [IW-1:0] idx_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          idx_q <= '0;
        end else if (slot_req) begin
          idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
      end
      assign page_idx  = idx_q;
      assign set_first = (idx_q == '0);
    end
  endgenerate
endmodule

// File: rtl/fcal_snapshot.sv
module fcal_snapshot
  import fcal_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int CAL_W = NUM_PAGES * PAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CAL_W-1:0] cal_live,
  output logic [CAL_W-1:0] cal_held
);
  logic [CAL_W-1:0] held_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '1;
    end else if (capture) begin
      held_q <= cal_live;
    end
  end
  assign cal_held = held_q;
endmodule

// File: rtl/fcal_page_mux.sv
module fcal_page_mux
  import fcal_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int CAL_W = NUM_PAGES * PAGE_W,
  localparam int IW = idx_width(NUM_PAGES)
) (
  input  logic              slot_req,
  input  logic              set_first,
  input  logic [IW-1:0]     page_idx,
  input  logic [CAL_W-1:0]  cal_live,
  input  logic [CAL_W-1:0]  cal_held,
  output logic              rst_flag,
  output logic [PAGE_W-1:0] page,
  output logic [CW_W-1:0]   overlay
);
  logic [PAGE_W-1:0] live_pg [NUM_PAGES];
  logic [PAGE_W-1:0] held_pg [NUM_PAGES];
  logic [PAGE_W-1:0] sel_pg;

  genvar g;
  generate
    for (g = 0; g < NUM_PAGES; g++) begin : g_pages
      // position 0 is the most significant page
      assign live_pg[g] = cal_live[(NUM_PAGES-1-g)*PAGE_W +: PAGE_W];
      assign held_pg[g] = cal_held[(NUM_PAGES-1-g)*PAGE_W +: PAGE_W];
    end
  endgenerate

  always_comb begin
    sel_pg = set_first ? live_pg[page_idx] : held_pg[page_idx];
  end

  assign rst_flag = slot_req & set_first;
  assign page     = slot_req ? sel_pg : '0;

  generate
    for (g = 0; g < CW_W; g++) begin : g_ovl
      if (g == RST_BIT) begin : g_flag
        assign overlay[g] = rst_flag;
      end else if (g >= FC_LSB && g <= FC_MSB) begin : g_fc
        assign overlay[g] = page[g-FC_LSB];
      end else begin : g_zero
        assign overlay[g] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/fcal_tx.sv
module fcal_tx
  import fcal_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int CAL_W = NUM_PAGES * PAGE_W,
  localparam int IW = idx_width(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAL_W-1:0]  cal_in,
  input  logic              slot_req,
  output logic              cw_rst_cal,
  output logic [PAGE_W-1:0] cw_fc_page,
  output logic [CW_W-1:0]   cw_overlay
);
  logic [IW-1:0]    page_idx;
  logic             set_first;
  logic [CAL_W-1:0] cal_held;

  fcal_page_seq #(.NUM_PAGES(NUM_PAGES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_req  (slot_req),
    .page_idx  (page_idx),
    .set_first (set_first)
  );

  fcal_snapshot #(.NUM_PAGES(NUM_PAGES)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (slot_req & set_first),
    .cal_live (cal_in),
    .cal_held (cal_held)
  );

  fcal_page_mux #(.NUM_PAGES(NUM_PAGES)) u_mux (
    .slot_req  (slot_req),
    .set_first (set_first),
    .page_idx  (page_idx),
    .cal_live  (cal_in),
    .cal_held  (cal_held),
    .rst_flag  (cw_rst_cal),
    .page      (cw_fc_page),
    .overlay   (cw_overlay)
  );
endmodule

// File: rtl/fcal_tx_chk.sv
module fcal_tx_chk
  import fcal_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int CAL_W = NUM_PAGES * PAGE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CAL_W-1:0]  cal_in,
  input logic              slot_req,
  input logic              cw_rst_cal,
  input logic [PAGE_W-1:0] cw_fc_page,
  input logic [CW_W-1:0]   cw_overlay
);
  int unsigned      pos;
  logic [CAL_W-1:0] snap;
  logic [PAGE_W-1:0] exp_held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= 0;
      snap <= '1;
    end else if (slot_req) begin
      if (pos == 0) snap <= cal_in;
      pos <= (pos == NUM_PAGES - 1) ? 0 : pos + 1;
    end
  end

  always_comb begin
    exp_held = snap[(NUM_PAGES-1-pos)*PAGE_W +: PAGE_W];
  end

  p_flag_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |-> (cw_rst_cal == (pos == 0)));

  p_live_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && pos == 0) |-> (cw_fc_page == cal_in[CAL_W-1 -: PAGE_W]));

  p_held_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && pos != 0) |-> (cw_fc_page == exp_held));

  p_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |-> (cw_overlay[RST_BIT] == cw_rst_cal &&
                  cw_overlay[FC_MSB:FC_LSB] == cw_fc_page &&
                  cw_overlay[CW_W-1:RST_BIT+1] == '0 &&
                  cw_overlay[FC_LSB-1:0] == '0));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_req |-> (cw_overlay == '0 && !cw_rst_cal));

  generate
    if (NUM_PAGES == 1) begin : g_one
      p_single_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |-> cw_rst_cal);
    end
  endgenerate
endmodule

bind fcal_tx fcal_tx_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cal_in     (cal_in),
  .slot_req   (slot_req),
  .cw_rst_cal (cw_rst_cal),
  .cw_fc_page (cw_fc_page),
  .cw_overlay (cw_overlay)
);

// File: tb/tb_fcal_tx.sv
module tb_fcal_tx;
  localparam int P = 4;
  localparam int W = P * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  cal4 = '1;
  logic [15:0]   cal1 = '1;
  logic          slot = 1'b0;
  logic          rf4, rf1;
  logic [15:0]   pg4, pg1;
  logic [63:0]   ov4, ov1;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [16:0] q4[$];
  logic [16:0] q1[$];
  string       t4[$];
  int          bidx = 0;
  logic [W-1:0] bsnap = '1;

  always #10 clk = ~clk;

  fcal_tx #(.NUM_PAGES(P)) dut (
    .clk(clk), .rst_n(rst_n), .cal_in(cal4), .slot_req(slot),
    .cw_rst_cal(rf4), .cw_fc_page(pg4), .cw_overlay(ov4));

  fcal_tx #(.NUM_PAGES(1)) dut_one (
    .clk(clk), .rst_n(rst_n), .cal_in(cal1), .slot_req(slot),
    .cw_rst_cal(rf1), .cw_fc_page(pg1), .cw_overlay(ov1));

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_slot(input logic [W-1:0] v4, input logic [15:0] v1,
                         input string tag);
    @(posedge clk); #1;
    cal4 = v4; cal1 = v1; slot = 1'b1;
    if (bidx == 0) bsnap = v4;
    q4.push_back({bidx == 0, bsnap[(P-1-bidx)*16 +: 16]});
    t4.push_back(tag);
    q1.push_back({1'b1, v1});
    bidx = (bidx + 1) % P;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    slot = 1'b0;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    slot = 1'b0; rst_n = 1'b0;
    bidx = 0; bsnap = '1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && slot) begin
        logic [16:0] e4, e1;
        string tg;
        e4 = q4.pop_front(); e1 = q1.pop_front(); tg = t4.pop_front();
        check({rf4, pg4} == e4, {tg, " R2 R3 flag/page"}, {47'b0, rf4, pg4}, {47'b0, e4});
        check(ov4 == {7'b0, e4[16], e4[15:0], 40'b0}, {tg, " R4 overlay"},
              ov4, {7'b0, e4[16], e4[15:0], 40'b0});
        check({rf1, pg1} == e1, "R8 single page", {47'b0, rf1, pg1}, {47'b0, e1});
      end else if (rst_n) begin
        check(ov4 == '0 && !rf4 && pg4 == '0, "R6 idle quiet", ov4, 64'h0);
        check(ov1 == '0 && !rf1, "R6 idle quiet single", ov1, 64'h0);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    // R1: first slot after reset; R2 order with known example
    do_slot(64'h1111_2222_3333_4444, 16'hA5A5, "R1");
    do_slot(64'h1111_2222_3333_4444, 16'h5A5A, "R2");
    do_slot(64'h1111_2222_3333_4444, 16'h0F0F, "R2");
    do_slot(64'h1111_2222_3333_4444, 16'hF0F0, "R2");
    // R7: wrap, new set
    do_slot(64'hFFFF_0000_FFFF_0000, 16'hFFFF, "R7");
    idle(3); // R6: position held through gap
    do_slot(64'h1234_5678_9ABC_DEF0, 16'h0000, "R6");
    idle(1);
    do_slot(64'h0, 16'h1234, "R6");
    do_slot(64'h0, 16'h4321, "R6");
    // R5: change calendar inside a set
    do_slot(64'hAAAA_BBBB_CCCC_DDDD, 16'h8001, "R5");
    do_slot(64'h0000_0000_0000_0000, 16'h0001, "R5");
    do_slot(64'hFFFF_FFFF_FFFF_FFFF, 16'h8000, "R5");
    do_slot(64'h1357_2468_1357_2468, 16'h7FFE, "R5");
    do_slot(64'h1357_2468_1357_2468, 16'h3C3C, "R7");
    // R1: reset in the middle of a set
    do_reset();
    do_slot(64'hCAFE_BEEF_0123_4567, 16'hBEEF, "R1");
    do_slot(64'hCAFE_BEEF_0123_4567, 16'hBEEF, "R2");
    do_slot(64'hCAFE_BEEF_0123_4567, 16'hBEEF, "R2");
    do_slot(64'hCAFE_BEEF_0123_4567, 16'hBEEF, "R2");
    // R9: all XON and all XOFF sets
    for (int i = 0; i < P; i++) do_slot('1, 16'hFFFF, "R9");
    for (int i = 0; i < P; i++) do_slot('0, 16'h0000, "R9");
    idle(2);
    @(negedge clk);
    check(q4.size() == 0, "R2 scoreboard drained", 64'(q4.size()), 64'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule